// File: doc/BRIEF.md
# Hierarchical Min-Difference Block Compressor

This block compresses one 8x8 block of 8-bit pixels without loss into a single variable-length packet. Each pixel is predicted from a hierarchy of block minima rather than from its neighbours. The block finds the least pixel of every 2x2 tile. It then finds the least of those tile minima inside every 4x4 quadrant, and finally the least of the four quadrant minima. The result is three levels of non-negative differences: quadrant minus block, tile minus quadrant, and pixel minus tile. Every difference is written with an order-0 Exp-Golomb code, so the small differences that dominate smooth video cost only one or a few bits.

A frame-memory writer presents all 64 pixels in parallel with a one-cycle start strobe. The block then works for a fixed number of cycles, appending one coded difference per cycle. When it finishes it presents the packet left-aligned in a 513-bit word, together with the packet length in bits and a one-cycle done pulse. If the coded form would exceed the raw form, the packet instead holds a raw-mode flag followed by the 64 pixels uncoded. Random access into the frame store then relies on the reported length.

Top module: `hmd_compressor`

## Requirements
- R1: Each pixel difference equals the pixel value minus the minimum of the 2x2 tile that contains it.
- R2: Each tile difference equals the tile minimum minus the minimum over the four tiles of its 4x4 quadrant.
- R3: The block-minimum field equals the least of all 64 pixels, and each quadrant difference equals the quadrant minimum minus that block minimum.
- R4: A difference v is coded as the binary form of v+1, most significant bit first, preceded by one fewer zero bits than that binary form has bits. Every code is therefore at least one bit long.
- R5: A coded packet is, from bit 512 downward: flag 1, the 8-bit block minimum, 4 quadrant differences, 16 tile differences, then 64 pixel differences. Quadrants are taken in raster order (top-left, top-right, bottom-left, bottom-right). Tiles are taken quadrant by quadrant, in raster order inside each quadrant. Pixels are taken tile by tile, in raster order inside each tile. Bits below the packet are zero. Pixel i (row*8+col) arrives on `pixels[8i+7:8i]`.
- R6: A raw packet is flag 0 in bit 512, then pixels 0 to 63 in index order, 8 bits each with pixel 0 in bits 511:504, and its length is 513.
- R7: Raw mode is chosen exactly when the coded length exceeds 513. A coded length of exactly 513 stays coded.
- R8: A block whose 64 pixels are all equal gives a coded packet of 93 bits. Every reported length lies between 93 and 513.
- R9: While `busy` is high, `start` is ignored. `done` is a one-cycle pulse, and `busy` is low in the cycle after it. The packet and length hold until the next completion.
- R10: After reset, `busy`, `done`, `pkt_len` and `packet` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin compressing `pixels` when idle |
| pixels | input | 512 | 64 pixels, pixel i in bits 8i+7:8i |
| busy | output | 1 | Compression in progress |
| done | output | 1 | One-cycle pulse: packet and length valid |
| packet | output | 513 | Packet, first field at the MSB |
| pkt_len | output | 10 | Packet length in bits |

## Verification
The assertions assume that `start` is only honoured from idle. They also assume that a pulse raised while busy must leave both the job and its result untouched. The stimulus tests this deliberately: it holds `start` high for several busy cycles with a different block, then waits for a spurious completion. The length assertions rely on every difference being non-negative and at most 255, which holds for any 8-bit input. Within that range the stimulus sweeps every flat block value, small-range and full-range random blocks, gradients, and two crafted blocks whose coded lengths sit exactly at 513 and just above it.

// File: rtl/hmd_pkg.sv
package hmd_pkg;
  localparam int PIX_W    = 8;
  localparam int BLK_SIDE = 8;
  localparam int N_PIX    = BLK_SIDE * BLK_SIDE;
  localparam int N_SUB    = N_PIX / 4;
  localparam int N_QUAD   = N_SUB / 4;
  localparam int N_ELEM   = N_QUAD + N_SUB + N_PIX;
  localparam int RAW_LEN  = 1 + N_PIX * PIX_W;
  localparam int MIN_LEN  = 1 + PIX_W + N_ELEM;
  localparam int CODE_MAX = 2 * PIX_W + 1;
  localparam int CODE_LW  = $clog2(CODE_MAX + 1);
  localparam int LEN_W    = $clog2(1 + PIX_W + N_ELEM * CODE_MAX + 1);
  localparam int OUT_LW   = $clog2(RAW_LEN + 1);
  localparam int IDX_W    = $clog2(N_ELEM);

  typedef enum logic [1:0] {S_IDLE, S_HEAD, S_CODE, S_FINAL} hmd_state_t;

  function automatic logic [PIX_W-1:0] min2(logic [PIX_W-1:0] a, logic [PIX_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // Order-0 Exp-Golomb code length for n = v+1: 2*msb(n)+1
  function automatic logic [CODE_LW-1:0] eg_len(logic [PIX_W:0] n);
    int msb;
    msb = 0;
    for (int i = 0; i <= PIX_W; i++)
      if (n[i]) msb = i;
    return CODE_LW'(2 * msb + 1);
  endfunction

  // Hierarchical index (quadrant, tile, pixel; each raster) to raster index
  function automatic int hier_to_raster(int h);
    int q, k, j, row, col;
    q = h / 16;
    k = (h / 4) % 4;
    j = h % 4;
    row = (q / 2) * 4 + (k / 2) * 2 + (j / 2);
    col = (q % 2) * 4 + (k % 2) * 2 + (j % 2);
    return row * BLK_SIDE + col;
  endfunction
endpackage

// File: rtl/hmd_min_tree.sv
module hmd_min_tree
  import hmd_pkg::*;
(
  input  logic [N_PIX*PIX_W-1:0]  pix,
  output logic [PIX_W-1:0]        blk_min,
  output logic [N_QUAD*PIX_W-1:0] qdiff,
  output logic [N_SUB*PIX_W-1:0]  sdiff,
  output logic [N_PIX*PIX_W-1:0]  pdiff
);
  logic [PIX_W-1:0] smin [N_SUB];
  logic [PIX_W-1:0] qmin [N_QUAD];

  for (genvar s = 0; s < N_SUB; s++) begin : g_sub
    logic [PIX_W-1:0] p [4];
    for (genvar j = 0; j < 4; j++) begin : g_px
      localparam int RIDX = hier_to_raster(s * 4 + j);
      assign p[j] = pix[RIDX*PIX_W +: PIX_W];
      assign pdiff[(s*4+j)*PIX_W +: PIX_W] = p[j] - smin[s];
    end
    assign smin[s] = min2(min2(p[0], p[1]), min2(p[2], p[3]));
  end

  for (genvar q = 0; q < N_QUAD; q++) begin : g_quad
    assign qmin[q] = min2(min2(smin[q*4], smin[q*4+1]), min2(smin[q*4+2], smin[q*4+3]));
    for (genvar k = 0; k < 4; k++) begin : g_sd
      assign sdiff[(q*4+k)*PIX_W +: PIX_W] = smin[q*4+k] - qmin[q];
    end
    assign qdiff[q*PIX_W +: PIX_W] = qmin[q] - blk_min;
  end

  assign blk_min = min2(min2(qmin[0], qmin[1]), min2(qmin[2], qmin[3]));
endmodule

// File: rtl/hmd_packer.sv
module hmd_packer
  import hmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic                 push,
  input  logic [PIX_W-1:0]     head_min,
  input  logic [PIX_W-1:0]     elem,
  output logic [RAW_LEN-1:0]   acc,
  output logic [LEN_W-1:0]     len
);
  logic [PIX_W:0]       code_val;
  logic [CODE_LW-1:0]   code_len;

  assign code_val = {1'b0, elem} + 1'b1;
  assign code_len = eg_len(code_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      len <= '0;
    end else if (init) begin
      acc <= {{(RAW_LEN-PIX_W-1){1'b0}}, 1'b1, head_min};
      len <= LEN_W'(1 + PIX_W);
    end else if (push) begin
      acc <= (acc << code_len) | {{(RAW_LEN-PIX_W-1){1'b0}}, code_val};
      len <= len + LEN_W'(code_len);
    end
  end

  AST_LEN_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (len > $past(len))); // R4
  AST_HEAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (len == LEN_W'(1 + PIX_W))); // R5
endmodule

// File: rtl/hmd_compressor.sv
module hmd_compressor
  import hmd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [N_PIX*PIX_W-1:0] pixels,
  output logic                   busy,
  output logic                   done,
  output logic [RAW_LEN-1:0]     packet,
  output logic [OUT_LW-1:0]      pkt_len
);
  hmd_state_t state;
  logic [N_PIX*PIX_W-1:0] pix_q;
  logic [IDX_W-1:0]       idx;
  logic [PIX_W-1:0]       blk_min, elem;
  logic [N_QUAD*PIX_W-1:0] qdiff;
  logic [N_SUB*PIX_W-1:0]  sdiff;
  logic [N_PIX*PIX_W-1:0]  pdiff;
  logic [N_ELEM*PIX_W-1:0] all_diff;
  logic [RAW_LEN-1:0]      acc;
  logic [LEN_W-1:0]        coded_len;
  logic [RAW_LEN-2:0]      raw_body;
  logic                    head_w, push_w, finalize_w, go_raw;

  hmd_min_tree u_tree (
    .pix(pix_q), .blk_min(blk_min), .qdiff(qdiff), .sdiff(sdiff), .pdiff(pdiff)
  );

  assign all_diff = {pdiff, sdiff, qdiff};
  assign elem     = all_diff[idx*PIX_W +: PIX_W];

  assign head_w     = (state == S_HEAD);
  assign push_w     = (state == S_CODE);
  assign finalize_w = (state == S_FINAL);
  assign busy       = (state != S_IDLE);
  assign go_raw     = coded_len > LEN_W'(RAW_LEN);

  hmd_packer u_pack (
    .clk(clk), .rst_n(rst_n), .init(head_w), .push(push_w),
    .head_min(blk_min), .elem(elem), .acc(acc), .len(coded_len)
  );

  for (genvar i = 0; i < N_PIX; i++) begin : g_raw
    assign raw_body[RAW_LEN-2-i*PIX_W -: PIX_W] = pix_q[i*PIX_W +: PIX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pix_q   <= '0;
      idx     <= '0;
      done    <= 1'b0;
      packet  <= '0;
      pkt_len <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          pix_q <= pixels;
          state <= S_HEAD;
        end
        S_HEAD: begin
          idx   <= '0;
          state <= S_CODE;
        end
        S_CODE: begin
          if (idx == IDX_W'(N_ELEM - 1)) state <= S_FINAL;
          else idx <= idx + 1'b1;
        end
        S_FINAL: begin
          state <= S_IDLE;
          done  <= 1'b1;
          if (go_raw) begin
            packet  <= {1'b0, raw_body};
            pkt_len <= OUT_LW'(RAW_LEN);
          end else begin
            packet  <= acc << (LEN_W'(RAW_LEN) - coded_len);
            pkt_len <= OUT_LW'(coded_len);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finalize_w) |=> busy); // R9
  AST_RAW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !packet[RAW_LEN-1]) |-> (pkt_len == OUT_LW'(RAW_LEN))); // R6
  AST_CODED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pkt_len < OUT_LW'(RAW_LEN)) |-> packet[RAW_LEN-1]); // R7
  AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pkt_len >= OUT_LW'(MIN_LEN) && pkt_len <= OUT_LW'(RAW_LEN))); // R8
endmodule

// File: tb/hmd_compressor_test.sv
module hmd_compressor_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [511:0] pixels = '0;
  logic         busy, done;
  logic [512:0] packet;
  logic [9:0]   pkt_len;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0]   img [64];
  bit   [0:1600] bs;
  int           ptr;
  logic [512:0] ep;
  int           el;

  always #2 clk = ~clk;

  hmd_compressor uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pixels(pixels),
    .busy(busy), .done(done), .packet(packet), .pkt_len(pkt_len)
  );

  task automatic check(input bit ok, input string req, input logic [512:0] act, input logic [512:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic emit(input int v, input int nbits);
    for (int b = nbits - 1; b >= 0; b--) begin
      bs[ptr] = v[b];
      ptr++;
    end
  endtask

  task automatic emit_eg(input int v);
    int n, nb, t;
    n = v + 1; nb = 0; t = n;
    while (t != 0) begin nb++; t = t >> 1; end
    emit(0, nb - 1);
    emit(n, nb);
  endtask

  // Independent model built from the requirements
  task automatic model();
    int smin [4][4];
    int qmin [2][2];
    int bmin;
    bs = '0; ptr = 0;
    for (int tr = 0; tr < 4; tr++)
      for (int tc = 0; tc < 4; tc++) begin
        smin[tr][tc] = 255;
        for (int dr = 0; dr < 2; dr++)
          for (int dc = 0; dc < 2; dc++)
            if (int'(img[(tr*2+dr)*8 + tc*2+dc]) < smin[tr][tc])
              smin[tr][tc] = img[(tr*2+dr)*8 + tc*2+dc];
      end
    bmin = 255;
    for (int qr = 0; qr < 2; qr++)
      for (int qc = 0; qc < 2; qc++) begin
        qmin[qr][qc] = 255;
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++)
            if (smin[qr*2+a][qc*2+b] < qmin[qr][qc]) qmin[qr][qc] = smin[qr*2+a][qc*2+b];
        if (qmin[qr][qc] < bmin) bmin = qmin[qr][qc];
      end
    emit(1, 1);
    emit(bmin, 8);
    for (int q = 0; q < 4; q++) emit_eg(qmin[q/2][q%2] - bmin);
    for (int q = 0; q < 4; q++)
      for (int k = 0; k < 4; k++)
        emit_eg(smin[(q/2)*2 + k/2][(q%2)*2 + k%2] - qmin[q/2][q%2]);
    for (int q = 0; q < 4; q++)
      for (int k = 0; k < 4; k++)
        for (int j = 0; j < 4; j++) begin
          int r, c;
          r = (q/2)*4 + (k/2)*2 + j/2;
          c = (q%2)*4 + (k%2)*2 + j%2;
          emit_eg(int'(img[r*8+c]) - smin[r/2][c/2]);
        end
    ep = '0;
    if (ptr > 513) begin
      for (int i = 0; i < 64; i++) ep[511-8*i -: 8] = img[i];
      el = 513;
    end else begin
      for (int i = 0; i < ptr; i++) ep[512-i] = bs[i];
      el = ptr;
    end
  endtask

  task automatic run_block(input string req);
    int wd;
    model();
    @(negedge clk);
    for (int i = 0; i < 64; i++) pixels[8*i +: 8] = img[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wd = 0;
    while (!done && wd < 500) begin @(negedge clk); wd++; end
    check(done, {req, " watchdog"}, 513'(wd), 513'(0));
    check(packet == ep, {req, " packet"}, packet, ep);
    check(int'(pkt_len) == el, {req, " length"}, 513'(pkt_len), 513'(el));
    @(negedge clk);
    check(!done && !busy, "R9 pulse/idle", {busy, done}, 513'(0));
    check(packet == ep, "R9 hold", packet, ep);
  endtask

  initial begin
    #(4 * 190000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && pkt_len == 0 && packet == 0, "R10 reset", packet, 513'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R8 / R3: every flat block
    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < 64; i++) img[i] = 8'(v);
      run_block("R8 flat");
      check(pkt_len == 10'd93 && packet[511:504] == 8'(v), "R8 len93 R3 min", 513'(pkt_len), 513'(93));
    end

    // R1 R2 R4 R5: small-range random blocks
    for (int n = 0; n < 150; n++) begin
      int base, span;
      base = $urandom % 200; span = 1 + (n % 12);
      for (int i = 0; i < 64; i++) img[i] = 8'(base + ($urandom % span));
      run_block("R1 R2 R4 R5 small-range");
    end

    // R3: quadrant offsets over a flat background
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < 64; i++) img[i] = 8'(10 + ((i / 32) * 2 + (i % 8) / 4) * n);
      run_block("R3 quadrant steps");
    end

    // gradients
    for (int n = 1; n < 6; n++) begin
      for (int i = 0; i < 64; i++) img[i] = 8'((i / 8) * n + (i % 8));
      run_block("R5 gradient");
    end

    // R6: full-range noise
    for (int n = 0; n < 30; n++) begin
      for (int i = 0; i < 64; i++) img[i] = 8'($urandom);
      run_block("R6 raw");
      check(packet[512] == (el < 513 || ptr == 513), "R6 flag", 513'(packet[512]), 513'(0));
    end

    // R7: exact 513 tie stays coded, 515 goes raw
    for (int i = 0; i < 64; i++) img[i] = 8'(0);
    for (int s = 0, cnt = 0; s < 16; s++)
      for (int j = 1; j < 4; j++) begin
        int h, r, c;
        h = s * 4 + j;
        r = (h/32)*4 + ((h/8)%2)*2 + ((h%4)/2);
        c = ((h/16)%2)*4 + ((h/4)%2)*2 + (h%2);
        img[r*8+c] = (cnt < 6) ? 8'd127 : 8'd15;
        cnt++;
      end
    run_block("R7 tie");
    check(packet[512] == 1'b1 && pkt_len == 10'd513, "R7 tie coded", 513'(pkt_len), 513'(513));
    for (int i = 0; i < 64; i++)
      if (img[i] == 8'd15) begin img[i] = 8'd31; break; end
    run_block("R7 over");
    check(packet[512] == 1'b0 && pkt_len == 10'd513, "R7 over raw", 513'(packet[512]), 513'(0));

    // R9: start while busy is ignored
    for (int i = 0; i < 64; i++) img[i] = 8'(i % 5);
    model();
    @(negedge clk);
    for (int i = 0; i < 64; i++) pixels[8*i +: 8] = img[i];
    start = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) pixels[8*i +: 8] = 8'(200 - i);
    repeat (5) @(negedge clk);
    start = 1'b0;
    begin
      int wd;
      wd = 0;
      while (!done && wd < 500) begin @(negedge clk); wd++; end
      check(packet == ep && int'(pkt_len) == el, "R9 busy ignore", packet, ep);
      begin
        bit extra;
        extra = 0;
        for (int c = 0; c < 120; c++) begin @(negedge clk); if (done || busy) extra = 1; end
        check(!extra, "R9 no second job", 513'(extra), 513'(0));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule